// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot control and slot status registers of a hot-plug capable downstream port. Software reaches both registers through one configuration access port: a write strobe, a one-bit register select and byte enables. Reads are combinational on the register select. The slot side drives single-cycle pulses for a device arrival and an attention-button press. At reset the port also samples whether a card was already present at power-up.

Software treats every write to slot control as one command, and the block completes each command at once by raising the command-completed status. A write of one to the interlock-control bit flips the interlock-engaged status. That control bit itself always reads back as zero. A control write that turns the power controller off while the power indicator is set to off, with a card present, is a safe detach. The block flags it, clears presence and records a presence change.

One interrupt request is derived from the combined enable-and-status condition. With the message-enable input low, the request is a level that follows the condition. With it high, the request is a one-cycle message pulse on each change of the condition.

Top module: `hp_slot_ctrl`

## Requirements
- R1: A write with `cfg_addr`=0 updates only the bytes whose `cfg_be` bit is set, and only the writable control fields: bit 0 button enable, bit 3 presence-change enable, bit 4 command-done enable, bit 5 interrupt enable, bits 7:6 attention indicator, bits 9:8 power indicator, bit 10 power controller (1 = off). All other control bits read 0.
- R2: After reset, control reads 16'h00C0 (attention indicator = 2'b11, off; all else 0). Status reads 0, except that bit 6 (presence) equals `cold_present`.
- R3: Writing 1 to control bit 11 with `cfg_be[1]` set toggles status bit 7 (interlock engaged). Control bit 11 always reads 0.
- R4: Every write to control with any byte enable set sets status bit 4 (command completed) on the next cycle.
- R5: A write with `cfg_addr`=1 clears status bits 0 (button pressed), 3 (presence changed) and 4 (command completed) where the enabled data bits are 1. Status bits 6 and 7 are not changed by status writes.
- R6: The pending condition is true when control bit 5 is set and, for some supported bit k in {0,3,4}, both status bit k and control bit k are set.
- R7: With `msi_en` low, `irq_level` equals the pending condition of the current register contents. With `msi_en` high, `irq_level` is 0.
- R8: With `msi_en` high, `irq_msg` pulses for one cycle, one cycle after any edge that changes the pending condition. There is no pulse when a status write makes it fall, and none when a status bit that is already set is set again.
- R9: When unlocked, `dev_arrive` sets status bits 6, 3 and 0, and `attn_button` sets status bit 0. A card present at power-up only sets bit 6 and raises no event.
- R10: While status bit 7 is set, `dev_arrive` and `attn_button` change no status bit, and `hp_busy` pulses on the next cycle.
- R11: A control write with `cfg_be[1]` set, status bit 6 set, data bit 10 = 1 and data bits 9:8 = 2'b11 pulses `safe_detach`, clears status bit 6 and sets status bit 3.
- R12: An event that sets a status bit in the same cycle as a status write clearing that bit wins, and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cold_present | input | 1 | Card present at power-up, loaded into presence during reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Register select: 0 control, 1 status |
| cfg_be | input | 2 | Byte enables of the write |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data of the selected register |
| dev_arrive | input | 1 | Hot-added device arrival pulse |
| attn_button | input | 1 | Attention button press pulse |
| msi_en | input | 1 | 1 selects message pulses, 0 selects the level line |
| irq_level | output | 1 | Level interrupt request |
| irq_msg | output | 1 | One-cycle message interrupt request |
| hp_busy | output | 1 | Pulse: a hot-plug request was refused because the interlock is engaged |
| safe_detach | output | 1 | Pulse: the slot may be detached |

## Verification
Directed sequences first walk the enable and status combinations one at a time. A command-completed event with its enable shows the level path, its write-one-to-clear shows the level falling without a message, and a repeated arrival shows that re-setting a set bit stays silent. Locked arrivals, the interlock toggle, safe detach and a clear racing an arrival each isolate one rule. Random traffic then mixes partial byte enables, both registers, both interrupt modes and events. Each cycle is compared with a cycle model, which exposes wrong byte merging, wrong priority between clears and events, and spurious or missing message pulses.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
   // Control field positions. Event enables sit at the same bit index as
   // the status bit they qualify, so the pending test is a plain AND.
   localparam int CB_BTN_EN  = 0;
   localparam int CB_PDC_EN  = 3;
   localparam int CB_CMD_EN  = 4;
   localparam int CB_IRQ_EN  = 5;
   localparam int CB_AIND    = 6;   // two bits
   localparam int CB_PIND    = 8;   // two bits
   localparam int CB_PWR_OFF = 10;
   localparam int CB_ILK     = 11;

   // Status field positions
   localparam int SB_BTN     = 0;
   localparam int SB_PDC     = 3;
   localparam int SB_CMD     = 4;
   localparam int SB_PRES    = 6;
   localparam int SB_LOCKED  = 7;

   localparam logic [1:0]  IND_OFF      = 2'b11;
   localparam logic [15:0] CTL_WMASK    = 16'h07F9;
   localparam logic [15:0] CTL_RST      = 16'h00C0;
   localparam logic [15:0] EVT_ALL      = 16'h0019;
endpackage

// File: rtl/hp_slot_ctl_reg.sv
module hp_slot_ctl_reg
   import hp_slot_pkg::*;
#(
   parameter int REG_W     = 16,
   parameter int BE_W      = 2,
   parameter bit EN_DETACH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [BE_W-1:0]  be,
   input  logic [REG_W-1:0] wdata,
   input  logic             pres_q,
   output logic [REG_W-1:0] ctl_q,
   output logic [REG_W-1:0] ctl_d,
   output logic             ilk_toggle,
   output logic             detach_now,
   output logic             detach_q
);
   logic [REG_W-1:0] merged;

   for (genvar b = 0; b < BE_W; b++) begin : g_byte
      assign merged[b*8 +: 8] = be[b] ? wdata[b*8 +: 8] : ctl_q[b*8 +: 8];
   end

   assign ctl_d      = ctl_wr ? (merged & CTL_WMASK) : ctl_q;
   assign ilk_toggle = ctl_wr && be[CB_ILK/8] && wdata[CB_ILK];

   if (EN_DETACH) begin : g_detach
      assign detach_now = ctl_wr && be[CB_PWR_OFF/8] && pres_q &&
                          wdata[CB_PWR_OFF] && (wdata[CB_PIND +: 2] == IND_OFF);
   end else begin : g_no_detach
      assign detach_now = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q    <= CTL_RST;
         detach_q <= 1'b0;
      end else begin
         ctl_q    <= ctl_d;
         detach_q <= detach_now;
      end
   end
endmodule

// File: rtl/hp_slot_sts_reg.sv
module hp_slot_sts_reg
   import hp_slot_pkg::*;
#(
   parameter int REG_W = 16,
   parameter int BE_W  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cold_present,
   input  logic             sts_wr,
   input  logic             ctl_wr,
   input  logic [BE_W-1:0]  be,
   input  logic [REG_W-1:0] wdata,
   input  logic             ilk_toggle,
   input  logic             detach,
   input  logic             arrive,
   input  logic             button,
   output logic [REG_W-1:0] sts_q,
   output logic [REG_W-1:0] sts_d,
   output logic             busy_q
);
   logic [REG_W-1:0] clr;
   logic             locked;

   for (genvar b = 0; b < BE_W; b++) begin : g_clr
      assign clr[b*8 +: 8] = be[b] ? wdata[b*8 +: 8] : 8'h00;
   end

   assign locked = sts_q[SB_LOCKED];

   // Order of updates gives events priority over clears
   always_comb begin
      sts_d = sts_q;
      if (sts_wr) sts_d = sts_d & ~(clr & EVT_ALL);
      if (ilk_toggle) sts_d[SB_LOCKED] = ~sts_d[SB_LOCKED];
      if (detach) begin
         sts_d[SB_PRES] = 1'b0;
         sts_d[SB_PDC]  = 1'b1;
      end
      if (ctl_wr) sts_d[SB_CMD] = 1'b1;
      if (arrive && !locked) begin
         sts_d[SB_PRES] = 1'b1;
         sts_d[SB_PDC]  = 1'b1;
         sts_d[SB_BTN]  = 1'b1;
      end
      if (button && !locked) sts_d[SB_BTN] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q         <= '0;
         sts_q[SB_PRES] <= cold_present;
         busy_q        <= 1'b0;
      end else begin
         sts_q  <= sts_d;
         busy_q <= (arrive || button) && locked;
      end
   end
endmodule

// File: rtl/hp_slot_notify.sv
module hp_slot_notify
   import hp_slot_pkg::*;
#(
   parameter int               REG_W       = 16,
   parameter logic [REG_W-1:0] EVT_SUPPORT = 16'h0019,
   parameter bit               MSG_ON_FALL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] ctl_d,
   input  logic [REG_W-1:0] sts_d,
   input  logic             sts_wr,
   input  logic             msi_en,
   output logic             irq_level,
   output logic             irq_msg
);
   logic pend_d, pend_q, change;

   assign pend_d = ctl_d[CB_IRQ_EN] && (|(sts_d & ctl_d & EVT_SUPPORT));

   if (MSG_ON_FALL) begin : g_both_edges
      // a fall caused by software clearing status sends nothing
      assign change = (pend_d != pend_q) && !(sts_wr && !pend_d);
   end else begin : g_rise_only
      assign change = pend_d && !pend_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         irq_msg <= 1'b0;
      end else begin
         pend_q  <= pend_d;
         irq_msg <= msi_en && change;
      end
   end

   assign irq_level = !msi_en && pend_q;
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
   import hp_slot_pkg::*;
#(
   parameter int               REG_W       = 16,
   parameter logic [REG_W-1:0] EVT_SUPPORT = 16'h0019,
   parameter bit               EN_DETACH   = 1'b1,
   parameter bit               MSG_ON_FALL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cold_present,
   input  logic             cfg_wr,
   input  logic             cfg_addr,
   input  logic [1:0]       cfg_be,
   input  logic [15:0]      cfg_wdata,
   output logic [15:0]      cfg_rdata,
   input  logic             dev_arrive,
   input  logic             attn_button,
   input  logic             msi_en,
   output logic             irq_level,
   output logic             irq_msg,
   output logic             hp_busy,
   output logic             safe_detach
);
   localparam int BE_W = REG_W / 8;

   if (REG_W != 16) begin : g_bad_width
      $error("hp_slot_ctrl: REG_W must be 16");
   end
   if ((EVT_SUPPORT & ~EVT_ALL) != '0) begin : g_bad_support
      $error("hp_slot_ctrl: EVT_SUPPORT names an unknown event bit");
   end

   logic [REG_W-1:0] ctl_q, ctl_d, sts_q, sts_d;
   logic             ctl_wr, sts_wr, ilk_toggle, detach_now;

   assign ctl_wr = cfg_wr && !cfg_addr && (|cfg_be);
   assign sts_wr = cfg_wr &&  cfg_addr && (|cfg_be);

   hp_slot_ctl_reg #(.REG_W(REG_W), .BE_W(BE_W), .EN_DETACH(EN_DETACH)) u_ctl (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .be(cfg_be), .wdata(cfg_wdata),
      .pres_q(sts_q[SB_PRES]), .ctl_q(ctl_q), .ctl_d(ctl_d),
      .ilk_toggle(ilk_toggle), .detach_now(detach_now), .detach_q(safe_detach)
   );

   hp_slot_sts_reg #(.REG_W(REG_W), .BE_W(BE_W)) u_sts (
      .clk(clk), .rst_n(rst_n), .cold_present(cold_present), .sts_wr(sts_wr),
      .ctl_wr(ctl_wr), .be(cfg_be), .wdata(cfg_wdata), .ilk_toggle(ilk_toggle),
      .detach(detach_now), .arrive(dev_arrive), .button(attn_button),
      .sts_q(sts_q), .sts_d(sts_d), .busy_q(hp_busy)
   );

   hp_slot_notify #(.REG_W(REG_W), .EVT_SUPPORT(EVT_SUPPORT), .MSG_ON_FALL(MSG_ON_FALL)) u_ntf (
      .clk(clk), .rst_n(rst_n), .ctl_d(ctl_d), .sts_d(sts_d), .sts_wr(sts_wr),
      .msi_en(msi_en), .irq_level(irq_level), .irq_msg(irq_msg)
   );

   assign cfg_rdata = cfg_addr ? sts_q : ctl_q;
endmodule

// File: rtl/hp_slot_ctrl_chk.sv
module hp_slot_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cfg_wr,
   input logic        cfg_addr,
   input logic [1:0]  cfg_be,
   input logic [15:0] cfg_wdata,
   input logic [15:0] cfg_rdata,
   input logic        dev_arrive,
   input logic        attn_button,
   input logic        msi_en,
   input logic        irq_level,
   input logic        irq_msg,
   input logic        hp_busy,
   input logic        safe_detach,
   input logic [15:0] ctl_q,
   input logic [15:0] sts_q
);
   p_ilk_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_addr |-> !cfg_rdata[11]);

   p_ilk_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !cfg_addr && cfg_be[1] && cfg_wdata[11]) |=> (sts_q[7] != $past(sts_q[7])));

   p_cmd_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !cfg_addr && (|cfg_be)) |=> sts_q[4]);

   p_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_level |-> (ctl_q[5] && (|(sts_q & ctl_q & 16'h0019))));

   p_level_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
      msi_en |-> !irq_level);

   p_msg_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_msg |-> $past(msi_en));

   p_arrival_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_arrive && !sts_q[7]) |=> (sts_q[6] && sts_q[3] && sts_q[0]));

   p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((dev_arrive || attn_button) && sts_q[7]) |=> hp_busy);

   p_detach_r11: assert property (@(posedge clk) disable iff (!rst_n)
      safe_detach |-> sts_q[3]);
endmodule

bind hp_slot_ctrl hp_slot_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
   .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dev_arrive(dev_arrive),
   .attn_button(attn_button), .msi_en(msi_en), .irq_level(irq_level),
   .irq_msg(irq_msg), .hp_busy(hp_busy), .safe_detach(safe_detach),
   .ctl_q(ctl_q), .sts_q(sts_q)
);

// File: tb/hp_slot_ctrl_bench.sv
`timescale 1ns/1ps
module hp_slot_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cold_present = 1'b0;
   logic        cfg_wr = 1'b0;
   logic        cfg_addr = 1'b0;
   logic [1:0]  cfg_be = 2'b00;
   logic [15:0] cfg_wdata = 16'h0;
   logic [15:0] cfg_rdata;
   logic        dev_arrive = 1'b0;
   logic        attn_button = 1'b0;
   logic        msi_en = 1'b0;
   logic        irq_level, irq_msg, hp_busy, safe_detach;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // cycle model of the requirements
   logic [15:0] m_ctl, m_sts;
   logic        m_pend, e_msg, e_busy, e_det;

   always #5 clk = ~clk;

   hp_slot_ctrl u_hp_slot_ctrl (
      .clk(clk), .rst_n(rst_n), .cold_present(cold_present), .cfg_wr(cfg_wr),
      .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .dev_arrive(dev_arrive), .attn_button(attn_button), .msi_en(msi_en),
      .irq_level(irq_level), .irq_msg(irq_msg), .hp_busy(hp_busy), .safe_detach(safe_detach)
   );

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic pend_of(input logic [15:0] c, input logic [15:0] s);
      return c[5] && (|(s & c & 16'h0019));
   endfunction

   task automatic model_edge(input bit wr, input bit addr, input logic [1:0] be,
                             input logic [15:0] wd, input bit arr, input bit btn);
      logic [15:0] ben, nc, ns;
      bit cw, sw, locked;
      ben    = {{8{be[1]}}, {8{be[0]}}};
      cw     = wr && !addr && (|be);
      sw     = wr && addr && (|be);
      locked = m_sts[7];
      nc = cw ? (((m_ctl & ~ben) | (wd & ben)) & 16'h07F9) : m_ctl;
      ns = m_sts;
      if (sw) ns = ns & ~(wd & ben & 16'h0019);
      if (cw && be[1] && wd[11]) ns[7] = ~ns[7];
      e_det = cw && be[1] && m_sts[6] && wd[10] && (wd[9:8] == 2'b11);
      if (e_det) begin ns[6] = 1'b0; ns[3] = 1'b1; end
      if (cw) ns[4] = 1'b1;
      if (arr && !locked) ns = ns | 16'h0049;
      if (btn && !locked) ns[0] = 1'b1;
      e_busy = (arr || btn) && locked;
      e_msg  = msi_en && (pend_of(nc, ns) != m_pend) && !(sw && !pend_of(nc, ns));
      m_ctl  = nc;
      m_sts  = ns;
      m_pend = pend_of(nc, ns);
   endtask

   task automatic rd(input bit a, output logic [15:0] d);
      cfg_addr = a;
      #1;
      d = cfg_rdata;
   endtask

   task automatic step(input bit wr, input bit addr, input logic [1:0] be,
                       input logic [15:0] wd, input bit arr, input bit btn);
      logic [15:0] d;
      @(negedge clk);
      cfg_wr = wr; cfg_addr = addr; cfg_be = be; cfg_wdata = wd;
      dev_arrive = arr; attn_button = btn;
      @(posedge clk);
      model_edge(wr, addr, be, wd, arr, btn);
      #1;
      cfg_wr = 1'b0; dev_arrive = 1'b0; attn_button = 1'b0;
      chk(irq_level == (!msi_en && m_pend), "R7 irq_level", {15'h0, irq_level}, {15'h0, !msi_en && m_pend});
      chk(irq_msg == e_msg, "R8 irq_msg", {15'h0, irq_msg}, {15'h0, e_msg});
      chk(hp_busy == e_busy, "R10 hp_busy", {15'h0, hp_busy}, {15'h0, e_busy});
      chk(safe_detach == e_det, "R11 safe_detach", {15'h0, safe_detach}, {15'h0, e_det});
      rd(1'b0, d);
      chk(d == m_ctl, "R1 control read", d, m_ctl);
      rd(1'b1, d);
      chk(d == m_sts, "R5 status read", d, m_sts);
   endtask

   task automatic do_reset(input bit cold);
      @(negedge clk);
      rst_n = 1'b0; cold_present = cold;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_ctl = 16'h00C0; m_sts = {9'h0, cold, 6'h0}; m_pend = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin : stim
      logic [15:0] d;
      void'($urandom(32'd1234));
      do_reset(1'b1);
      rd(1'b0, d); chk(d == 16'h00C0, "R2 control after reset", d, 16'h00C0);
      rd(1'b1, d); chk(d == 16'h0040, "R9 cold presence only", d, 16'h0040);

      // enables + command completion, level mode
      step(1'b1, 1'b0, 2'b11, 16'h0039, 1'b0, 1'b0);
      rd(1'b1, d); chk(d[4] == 1'b1, "R4 command completed", d, 16'h0010);
      chk(irq_level == 1'b1, "R6 pending level", {15'h0, irq_level}, 16'h1);
      step(1'b1, 1'b1, 2'b01, 16'h0010, 1'b0, 1'b0);   // R5 clear, level drops
      @(negedge clk) msi_en = 1'b1;
      step(1'b0, 1'b0, 2'b00, 16'h0, 1'b1, 1'b0);      // R9 arrival, R8 pulse
      step(1'b0, 1'b0, 2'b00, 16'h0, 1'b1, 1'b0);      // R8 re-set, no pulse
      step(1'b1, 1'b0, 2'b10, 16'h0800, 1'b0, 1'b0);   // R3 engage interlock
      rd(1'b0, d); chk(d[11] == 1'b0, "R3 ilk control reads zero", d, m_ctl);
      rd(1'b1, d); chk(d[7] == 1'b1, "R3 interlock engaged", d, m_sts);
      step(1'b0, 1'b0, 2'b00, 16'h0, 1'b1, 1'b0);      // R10 refused
      step(1'b0, 1'b0, 2'b00, 16'h0, 1'b0, 1'b1);      // R10 refused button
      step(1'b1, 1'b0, 2'b10, 16'h0800, 1'b0, 1'b0);   // R3 release
      step(1'b1, 1'b0, 2'b11, 16'h0739, 1'b0, 1'b0);   // R11 detach
      step(1'b1, 1'b1, 2'b01, 16'h0008, 1'b1, 1'b0);   // R12 race
      rd(1'b1, d); chk(d[3] == 1'b1, "R12 event beats clear", d, m_sts);
      step(1'b1, 1'b0, 2'b01, 16'hFFFF, 1'b0, 1'b0);   // R1 low byte only
      do_reset(1'b0);
      rd(1'b1, d); chk(d == 16'h0000, "R2 status after reset", d, 16'h0000);

      for (int i = 0; i < 600; i++) begin
         logic [15:0] wd;
         bit wr, ad, ar, bt;
         wd = 16'($urandom);
         if (($urandom % 4) != 0) wd[11] = 1'b0;
         wr = ($urandom % 2) == 0;
         ad = ($urandom % 2) == 0;
         ar = ($urandom % 6) == 0;
         bt = ($urandom % 6) == 0;
         if (($urandom % 20) == 0) msi_en = ~msi_en;
         step(wr, ad, 2'($urandom), wd, ar, bt);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule